// File: doc/BRIEF.md
# Bus Wait-State Watchdog with DMA Ownership Arbiter

This block watches every cycle on a processor bus and makes sure the cycle ends. Once a cycle has started, it counts pulses of a slow timing strobe (nominally 8 MHz, one bus-clock wide) for as long as neither the address acknowledge nor the data acknowledge has arrived. If the count reaches a fixed budget (128 strobes, about 16 µs), the block drives an active-low transfer-error line for one bus clock. That error forces the stalled cycle to terminate.

An access whose target reports its own errors is marked with a flag at cycle start, for example a display controller. Such a cycle is never timed out. An address acknowledge restarts the budget for the data phase. A data acknowledge ends the cycle.

The same block decides who owns the bus. The processor owns it by default. A DMA request is granted only at a cycle boundary: no cycle outstanding, none starting, and the processor not reporting that it still holds the bus. Ownership goes back to the processor in the clock after the request drops.

Top module: `bus_wd_arbiter`

## Requirements
- R1: While reset is applied, and in the first clock after it, `xfer_err_n` is 1, `cpu_gnt` is 1 and `dma_gnt` is 0.
- R2: For an open, non-exempt cycle with both acknowledges high, each bus clock with `timing_tick` high adds one wait count. On the clock edge that carries the 128th such tick, `xfer_err_n` goes low; it is low from that edge to the next.
- R3: `xfer_err_n` stays low for exactly one bus clock.
- R4: A low `addr_ack_n` or `data_ack_n` clears the wait count, and a tick on that same edge is not counted. A low `data_ack_n` also ends the cycle, so no error follows. An acknowledge on the edge that would have raised the error suppresses that error.
- R5: A `cyc_start` pulse clears the wait count and opens a new cycle, even while a cycle is already open. A tick on the start edge is not counted.
- R6: A cycle started with `tgt_own_err` = 1 is never timed out, however long its acknowledges stay high.
- R7: After an error, the cycle is closed, and no further error occurs until a new `cyc_start`, even if neither acknowledge ever arrives.
- R8: `dma_gnt` rises only in the clock after an edge at which `dma_req` = 1, no cycle is open, `cyc_start` = 0 and `cpu_bus_busy` = 0.
- R9: While DMA owns the bus, an edge with `dma_req` = 0 returns ownership to the processor: `cpu_gnt` = 1 from that edge on.
- R10: Exactly one of `cpu_gnt` and `dma_gnt` is high at all times.
- R11: When no cycle is open, ticks have no effect and `xfer_err_n` stays 1 in the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_tick | input | 1 | One-clock pulse of the slow wait-timing strobe |
| cyc_start | input | 1 | Bus cycle start strobe |
| addr_ack_n | input | 1 | Active-low address acknowledge |
| data_ack_n | input | 1 | Active-low data (transfer) acknowledge; ends the cycle |
| tgt_own_err | input | 1 | Sampled with `cyc_start`: target raises its own errors, exempt from timeout |
| dma_req | input | 1 | DMA controller bus request |
| cpu_bus_busy | input | 1 | Processor reports it still holds the bus |
| xfer_err_n | output | 1 | Active-low transfer error, one clock wide |
| dma_gnt | output | 1 | Bus granted to DMA |
| cpu_gnt | output | 1 | Bus granted to processor |

## Verification
Some rules are checked by assertions on every clock: the error pulse is one clock wide, an error closes its cycle, an exempt or idle cycle stays silent, the count moves only on ticks and clears on acknowledges, and the grants stay mutually exclusive and change only under the stated conditions. The exact clock of the error depends on how far the tick rate, the tick phase and the acknowledge timing push the budget. Only the bench's sweeps can show that. They vary tick period, acknowledge kind and arrival point, and compare each clock against a closed-form expected edge. The bench scenarios also cover the DMA hand-over sequence around an open cycle.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_DMA = 1'b1
  } bus_owner_e;

  // Wait count after one more counted tick.
  function automatic int unsigned wait_step(input int unsigned cnt);
    return cnt + 1;
  endfunction

  // True when the tick about to be counted is the last one of the budget.
  function automatic logic budget_spent(input int unsigned cnt,
                                        input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/bwa_cycle_track.sv
module bwa_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic data_ack_n,
  input  logic tgt_own_err,
  input  logic timeout_fire,
  output logic cyc_open,
  output logic cyc_exempt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_open   <= 1'b0;
      cyc_exempt <= 1'b0;
    end else if (cyc_start) begin
      cyc_open   <= 1'b1;
      cyc_exempt <= tgt_own_err;
    end else if (!data_ack_n || timeout_fire) begin
      cyc_open   <= 1'b0;
      cyc_exempt <= 1'b0;
    end
  end

  // A timeout always closes its cycle, so it cannot repeat.
  assert_err_closes_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fire |=> !cyc_open);

  // A new cycle is open right after its start strobe.
  assert_start_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> cyc_open);

endmodule

// File: rtl/bwa_wait_timer.sv
module bwa_wait_timer #(
  parameter int unsigned WAIT_LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timing_tick,
  input  logic cyc_start,
  input  logic cyc_open,
  input  logic cyc_exempt,
  input  logic addr_ack_n,
  input  logic data_ack_n,
  output logic timeout_fire,
  output logic err_q
);
  import bwa_pkg::*;

  localparam int unsigned CW = $clog2(WAIT_LIMIT + 1);

  logic [CW-1:0] wait_cnt;
  logic          ack_seen;
  logic          waiting;
  logic          count_now;

  assign ack_seen     = !addr_ack_n || !data_ack_n;
  assign waiting      = cyc_open && !cyc_exempt && !ack_seen && !cyc_start;
  assign count_now    = waiting && timing_tick;
  assign timeout_fire = count_now && budget_spent(32'(wait_cnt), WAIT_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (cyc_start || ack_seen || timeout_fire) begin
      wait_cnt <= '0;
    end else if (count_now) begin
      wait_cnt <= CW'(wait_step(32'(wait_cnt)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= timeout_fire;
  end

  assert_err_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  assert_count_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt > $past(wait_cnt)) |-> $past(timing_tick));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |=> (wait_cnt == '0));

  assert_count_in_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wait_cnt) < WAIT_LIMIT);

endmodule

// File: rtl/bwa_arbiter.sv
module bwa_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic cpu_bus_busy,
  input  logic cyc_open,
  input  logic cyc_start,
  output logic dma_gnt,
  output logic cpu_gnt
);
  import bwa_pkg::*;

  bus_owner_e owner, owner_nx;
  logic       boundary_free;

  assign boundary_free = !cyc_open && !cyc_start && !cpu_bus_busy;

  always_comb begin
    owner_nx = owner;
    unique case (owner)
      OWN_CPU: if (dma_req && boundary_free) owner_nx = OWN_DMA;
      OWN_DMA: if (!dma_req)                 owner_nx = OWN_CPU;
      default: owner_nx = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_CPU;
    else        owner <= owner_nx;
  end

  assign dma_gnt = (owner == OWN_DMA);
  assign cpu_gnt = (owner == OWN_CPU);

  assert_grant_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({dma_gnt, cpu_gnt}));

  assert_dma_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt) |-> $past(dma_req && !cyc_open && !cyc_start && !cpu_bus_busy));

  assert_dma_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !dma_req) |=> cpu_gnt);

endmodule

// File: rtl/bus_wd_arbiter.sv
module bus_wd_arbiter #(
  parameter int unsigned WAIT_LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timing_tick,
  input  logic cyc_start,
  input  logic addr_ack_n,
  input  logic data_ack_n,
  input  logic tgt_own_err,
  input  logic dma_req,
  input  logic cpu_bus_busy,
  output logic xfer_err_n,
  output logic dma_gnt,
  output logic cpu_gnt
);

  logic cyc_open;
  logic cyc_exempt;
  logic timeout_fire;
  logic err_q;

  bwa_cycle_track u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_start    (cyc_start),
    .data_ack_n   (data_ack_n),
    .tgt_own_err  (tgt_own_err),
    .timeout_fire (timeout_fire),
    .cyc_open     (cyc_open),
    .cyc_exempt   (cyc_exempt)
  );

  bwa_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .timing_tick  (timing_tick),
    .cyc_start    (cyc_start),
    .cyc_open     (cyc_open),
    .cyc_exempt   (cyc_exempt),
    .addr_ack_n   (addr_ack_n),
    .data_ack_n   (data_ack_n),
    .timeout_fire (timeout_fire),
    .err_q        (err_q)
  );

  bwa_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_req      (dma_req),
    .cpu_bus_busy (cpu_bus_busy),
    .cyc_open     (cyc_open),
    .cyc_start    (cyc_start),
    .dma_gnt      (dma_gnt),
    .cpu_gnt      (cpu_gnt)
  );

  assign xfer_err_n = !err_q;

  assert_exempt_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_open && cyc_exempt && !cyc_start) |=> xfer_err_n);

  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_open |=> xfer_err_n);

endmodule

// File: tb/tb_bus_wd_arbiter.sv
module tb_bus_wd_arbiter;

  localparam int unsigned LIMIT = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic timing_tick = 1'b0;
  logic cyc_start = 1'b0;
  logic addr_ack_n = 1'b1;
  logic data_ack_n = 1'b1;
  logic tgt_own_err = 1'b0;
  logic dma_req = 1'b0;
  logic cpu_bus_busy = 1'b0;
  logic xfer_err_n, dma_gnt, cpu_gnt;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_wd_arbiter #(.WAIT_LIMIT(LIMIT)) dut (
    .clk, .rst_n, .timing_tick, .cyc_start, .addr_ack_n, .data_ack_n,
    .tgt_own_err, .dma_req, .cpu_bus_busy, .xfer_err_n, .dma_gnt, .cpu_gnt
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      timing_tick = 1'b1;
      @(negedge clk);
      chk("R11 idle", xfer_err_n, 1'b1);
    end
    timing_tick = 1'b0;
  endtask

  // kind: 0 no acknowledge, 1 address ack at a, 2 data ack at a, 3 restart at a
  task automatic run_case(input int p, input int kind, input int a, input bit exempt);
    int e;
    int kmax;
    string tag;
    if (exempt || kind == 2) e = -1;
    else if (kind == 0)      e = p * LIMIT;
    else                     e = (a / p + LIMIT) * p;
    kmax = (e > 0) ? e + 6 : 2 * p * LIMIT + 4;
    cyc_start = 1'b1; tgt_own_err = exempt; timing_tick = 1'b0;
    @(negedge clk);
    cyc_start = 1'b0; tgt_own_err = 1'b0;
    for (int k = 1; k <= kmax; k++) begin
      timing_tick = (k % p == 0);
      addr_ack_n  = !(kind == 1 && k == a);
      data_ack_n  = !(kind == 2 && k == a);
      cyc_start   = (kind == 3 && k == a);
      @(negedge clk);
      if (exempt)                  tag = "R6 exempt";
      else if (k == e)             tag = "R2 timeout edge";
      else if (e > 0 && k == e+1)  tag = "R3 one-clock pulse";
      else if (e > 0 && k > e+1)   tag = "R7 single error";
      else if (kind == 3)          tag = "R5 restart";
      else                         tag = "R4 acknowledge";
      chk(tag, xfer_err_n, !(k == e));
    end
    timing_tick = 1'b0; addr_ack_n = 1'b1; data_ack_n = 1'b1; cyc_start = 1'b0;
    // close any still-open cycle before the next case
    data_ack_n = 1'b0;
    @(negedge clk);
    data_ack_n = 1'b1;
    idle(3);
  endtask

  initial begin
    int pl;
    repeat (3) @(negedge clk);
    chk("R1 reset err", xfer_err_n, 1'b1);
    chk("R1 reset cpu", cpu_gnt, 1'b1);
    chk("R1 reset dma", dma_gnt, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset err", xfer_err_n, 1'b1);
    chk("R1 post-reset cpu", cpu_gnt, 1'b1);
    idle(4);

    foreach (pl_list[i]) begin
      pl = pl_list[i] * LIMIT;
      run_case(pl_list[i], 0, 0, 1'b0);
      run_case(pl_list[i], 0, 0, 1'b1);
      for (int kind = 1; kind <= 3; kind++) begin
        run_case(pl_list[i], kind, 1, 1'b0);
        run_case(pl_list[i], kind, pl_list[i], 1'b0);
        run_case(pl_list[i], kind, pl / 2, 1'b0);
        run_case(pl_list[i], kind, pl - 1, 1'b0);
        run_case(pl_list[i], kind, pl, 1'b0);
      end
    end
    for (int a = 2; a < int'(LIMIT); a += 9) begin
      run_case(1, 1, a, 1'b0);
      run_case(1, 3, a, 1'b0);
    end

    // DMA hand-over
    dma_req = 1'b1; cpu_bus_busy = 1'b1;
    @(negedge clk);
    chk("R8 busy cpu blocks dma", dma_gnt, 1'b0);
    cpu_bus_busy = 1'b0;
    @(negedge clk);
    chk("R8 grant at boundary", dma_gnt, 1'b1);
    chk("R10 cpu off", cpu_gnt, 1'b0);
    dma_req = 1'b0;
    @(negedge clk);
    chk("R9 return to cpu", cpu_gnt, 1'b1);
    chk("R10 dma off", dma_gnt, 1'b0);
    dma_req = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    chk("R8 start blocks dma", dma_gnt, 1'b0);
    @(negedge clk);
    chk("R8 open cycle blocks dma", dma_gnt, 1'b0);
    data_ack_n = 1'b0;
    @(negedge clk);
    data_ack_n = 1'b1;
    chk("R8 still open at ack edge", dma_gnt, 1'b0);
    @(negedge clk);
    chk("R8 grant after cycle end", dma_gnt, 1'b1);
    @(negedge clk);
    chk("R9 held while requested", dma_gnt, 1'b1);
    dma_req = 1'b0;
    @(negedge clk);
    chk("R9 released", cpu_gnt, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int pl_list[2] = '{1, 3};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (got hang, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule